// File: doc/BRIEF.md
# In-band Xon/Xoff flow controller

This block adds in-band software flow control to one serial channel. It watches every character the receiver delivers and compares it with four programmed bytes: a pause pair and a resume pair. In single-character mode the first byte of a pair is enough for a match. In two-character mode the first and second bytes must arrive back to back. A pause match suspends the local transmitter and raises a status flag, which can also drive an interrupt. A later resume match lifts the suspension. A character that is already being shifted out always finishes, because the block only withholds permission to start the next one.

In the other direction, the block watches the fill level of the local receive FIFO. It asks the transmitter to insert a pause character when the level climbs to a threshold picked by a 2-bit trigger select. It asks for a resume character once the level has drained to a lower partner threshold. This hysteresis is the same as the one used by hardware handshake flow control. A pending insertion blocks normal data and is handed over one character at a time on the transmitter's character-boundary pulse. Characters that complete a match are not forwarded to the receive FIFO.

Top module: `xonxoff_flow_ctrl`

## Requirements
- R1: `cmp_mode` encoding: 2'b00 = off, 2'b01 = single-character compare, 2'b10 or 2'b11 = two-character compare. When off, the block does no matching and raises no insertion request. One cycle after mode becomes off, `xoff_flag` and `fc_req` are 0 and `tx_allow` is 1. Every received character is forwarded.
- R2: In single mode, a received byte equal to `xoff_a` sets `xoff_flag` and clears `tx_allow` in the cycle after the strobe. A byte equal to `xon_a` clears the flag again. If both bytes match the same value, the pause match wins.
- R3: In two-character mode, a pause match needs `xoff_a` followed immediately by `xoff_b`, and a resume match needs `xon_a` followed immediately by `xon_b`. A resume pair that arrives while not suspended changes nothing except dropping the completing byte.
- R4: In two-character mode, any character other than the expected second byte cancels the partial match. That character is then judged as a possible first byte, so `xoff_a, xoff_a, xoff_b` is a pause match.
- R5: `xoff_flag` is set by a pause match and cleared by a resume match. `irq` equals `xoff_flag` AND `irq_en`.
- R6: With `trig_sel` equal to 0, 1, 2 or 3, a pause insertion is requested when `rx_fill` reaches at least 8, 16, 24 or 28. The matching resume insertion is requested when `rx_fill` falls to at most 0, 7, 15 or 23. Each request appears one cycle after the fill value that causes it.
- R7: One request is made per threshold crossing. A resume insertion is requested only after a pause insertion has been requested and fully handed over, so a low fill level after reset requests nothing.
- R8: `fc_req` stays high, with `fc_is_xon` and `fc_byte` naming the character, until `char_done` accepts it. While `fc_req` is high, `tx_allow` is 0, so insertions go ahead of normal data. In single mode one character is sent (`xoff_a` or `xon_a`). In two-character mode two characters are sent in order (`xoff_a` then `xoff_b`, or `xon_a` then `xon_b`), with one `char_done` pulse for each.
- R9: `fwd_valid` pulses one cycle after each `rx_strobe`, with `fwd_byte` equal to the received byte. There is no pulse for a single-mode match byte or for the second byte of a two-character match. The first byte of a pair is forwarded.
- R10: After reset, `tx_allow` is 1 and `fc_req`, `xoff_flag`, `irq` and `fwd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_mode | input | 2 | Off / single / two-character compare |
| rx_strobe | input | 1 | One-cycle pulse: a received character is valid |
| rx_byte | input | 8 | Received character |
| xon_a | input | 8 | First (or only) resume byte |
| xon_b | input | 8 | Second resume byte |
| xoff_a | input | 8 | First (or only) pause byte |
| xoff_b | input | 8 | Second pause byte |
| rx_fill | input | 6 | Local receive FIFO fill count |
| trig_sel | input | 2 | Threshold pair select |
| char_done | input | 1 | Transmitter character-boundary pulse |
| irq_en | input | 1 | Interrupt enable for the pause flag |
| tx_allow | output | 1 | Normal transmit data may start a character |
| fc_req | output | 1 | Insertion of a flow-control character requested |
| fc_is_xon | output | 1 | 1 = resume character, 0 = pause character |
| fc_byte | output | 8 | Character to insert |
| xoff_flag | output | 1 | Transmitter suspended by a received pause |
| irq | output | 1 | Pause interrupt |
| fwd_valid | output | 1 | Forward character to receive FIFO |
| fwd_byte | output | 8 | Forwarded character |

## Verification
The bench builds the block with its default parameters: 8-bit characters, a 32-entry FIFO (6-bit fill count) and four trigger pairs. With this small configuration it can run all 256 byte values through single-character matching. For every trigger select it also walks the fill count up from 0 to 32 and back down. This reaches every threshold edge, the once-per-crossing rule, and the rule that no resume is sent without an earlier pause. Directed two-character sequences cover broken pairs, a repeated first byte and a resume pair that arrives while not suspended.

// File: rtl/xf_pkg.sv
package xf_pkg;

  typedef enum logic [1:0] {
    PART_NONE = 2'd0,
    PART_OFF  = 2'd1,
    PART_ON   = 2'd2
  } part_t;

  function automatic logic mode_active(input logic [1:0] m);
    return m != 2'b00;
  endfunction

  function automatic logic mode_pair(input logic [1:0] m);
    return m[1];
  endfunction

endpackage

// File: rtl/xf_rx_match.sv
module xf_rx_match
  import xf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cmp_mode,
  input  logic          rx_strobe,
  input  logic [DW-1:0] rx_byte,
  input  logic [DW-1:0] xon_a,
  input  logic [DW-1:0] xon_b,
  input  logic [DW-1:0] xoff_a,
  input  logic [DW-1:0] xoff_b,
  output logic          hit_off,
  output logic          hit_on,
  output logic          fwd_valid,
  output logic [DW-1:0] fwd_byte
);

  part_t         part_q, part_d;
  logic          drop;
  logic          fwd_valid_q;
  logic [DW-1:0] fwd_byte_q;

  always_comb begin
    hit_off = 1'b0;
    hit_on  = 1'b0;
    drop    = 1'b0;
    part_d  = part_q;
    if (!mode_active(cmp_mode)) begin
      part_d = PART_NONE;
    end else if (rx_strobe) begin
      if (!mode_pair(cmp_mode)) begin
        part_d = PART_NONE;
        if (rx_byte == xoff_a) begin
          hit_off = 1'b1;
          drop    = 1'b1;
        end else if (rx_byte == xon_a) begin
          hit_on = 1'b1;
          drop   = 1'b1;
        end
      end else begin
        if (part_q == PART_OFF && rx_byte == xoff_b) begin
          hit_off = 1'b1;
          drop    = 1'b1;
          part_d  = PART_NONE;
        end else if (part_q == PART_ON && rx_byte == xon_b) begin
          hit_on = 1'b1;
          drop   = 1'b1;
          part_d = PART_NONE;
        end else if (rx_byte == xoff_a) begin
          part_d = PART_OFF;
        end else if (rx_byte == xon_a) begin
          part_d = PART_ON;
        end else begin
          part_d = PART_NONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_q      <= PART_NONE;
      fwd_valid_q <= 1'b0;
      fwd_byte_q  <= '0;
    end else begin
      part_q      <= part_d;
      fwd_valid_q <= rx_strobe && !drop;
      if (rx_strobe) begin
        fwd_byte_q <= rx_byte;
      end
    end
  end

  assign fwd_valid = fwd_valid_q;
  assign fwd_byte  = fwd_byte_q;

endmodule

// File: rtl/xf_suspend.sv
module xf_suspend (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic hit_off,
  input  logic hit_on,
  input  logic irq_en,
  output logic xoff_flag,
  output logic irq
);

  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (!active) begin
      flag_d = 1'b0;
    end else if (hit_off) begin
      flag_d = 1'b1;
    end else if (hit_on) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign xoff_flag = flag_q;
  assign irq       = flag_q & irq_en;

endmodule

// File: rtl/xf_insert.sv
module xf_insert #(
  parameter int DW       = 8,
  parameter int CNT_W    = 6,
  parameter int NUM_TRIG = 4,
  parameter int OFF_LVL [NUM_TRIG] = '{8, 16, 24, 28},
  parameter int ON_LVL  [NUM_TRIG] = '{0, 7, 15, 23}
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        active,
  input  logic                        pair,
  input  logic [CNT_W-1:0]            rx_fill,
  input  logic [$clog2(NUM_TRIG)-1:0] trig_sel,
  input  logic                        char_done,
  input  logic [DW-1:0]               xon_a,
  input  logic [DW-1:0]               xon_b,
  input  logic [DW-1:0]               xoff_a,
  input  logic [DW-1:0]               xoff_b,
  output logic                        fc_req,
  output logic                        fc_is_xon,
  output logic [DW-1:0]               fc_byte
);

  logic             pend_q, pend_d;
  logic             kind_q, kind_d;
  logic             idx_q, idx_d;
  logic             sent_q, sent_d;
  logic [CNT_W-1:0] hi_lvl, lo_lvl;

  assign hi_lvl = CNT_W'(OFF_LVL[trig_sel]);
  assign lo_lvl = CNT_W'(ON_LVL[trig_sel]);

  always_comb begin
    pend_d = pend_q;
    kind_d = kind_q;
    idx_d  = idx_q;
    sent_d = sent_q;
    if (!active) begin
      pend_d = 1'b0;
      idx_d  = 1'b0;
      sent_d = 1'b0;
    end else if (pend_q) begin
      if (char_done) begin
        if (pair && !idx_q) begin
          idx_d = 1'b1;
        end else begin
          pend_d = 1'b0;
          idx_d  = 1'b0;
        end
      end
    end else if (!sent_q && rx_fill >= hi_lvl) begin
      pend_d = 1'b1;
      kind_d = 1'b0;
      idx_d  = 1'b0;
      sent_d = 1'b1;
    end else if (sent_q && rx_fill <= lo_lvl) begin
      pend_d = 1'b1;
      kind_d = 1'b1;
      idx_d  = 1'b0;
      sent_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      kind_q <= 1'b0;
      idx_q  <= 1'b0;
      sent_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      kind_q <= kind_d;
      idx_q  <= idx_d;
      sent_q <= sent_d;
    end
  end

  assign fc_req    = pend_q;
  assign fc_is_xon = kind_q;
  assign fc_byte   = kind_q ? (idx_q ? xon_b : xon_a)
                            : (idx_q ? xoff_b : xoff_a);

endmodule

// File: rtl/xonxoff_flow_ctrl.sv
module xonxoff_flow_ctrl
  import xf_pkg::*;
#(
  parameter int DW         = 8,
  parameter int FIFO_DEPTH = 32,
  parameter int NUM_TRIG   = 4,
  parameter int OFF_LVL [NUM_TRIG] = '{8, 16, 24, 28},
  parameter int ON_LVL  [NUM_TRIG] = '{0, 7, 15, 23},
  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1),
  localparam int TRIG_W = $clog2(NUM_TRIG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmp_mode,
  input  logic              rx_strobe,
  input  logic [DW-1:0]     rx_byte,
  input  logic [DW-1:0]     xon_a,
  input  logic [DW-1:0]     xon_b,
  input  logic [DW-1:0]     xoff_a,
  input  logic [DW-1:0]     xoff_b,
  input  logic [CNT_W-1:0]  rx_fill,
  input  logic [TRIG_W-1:0] trig_sel,
  input  logic              char_done,
  input  logic              irq_en,
  output logic              tx_allow,
  output logic              fc_req,
  output logic              fc_is_xon,
  output logic [DW-1:0]     fc_byte,
  output logic              xoff_flag,
  output logic              irq,
  output logic              fwd_valid,
  output logic [DW-1:0]     fwd_byte
);

  logic active;
  logic pair;
  logic hit_off, hit_on;

  assign active = mode_active(cmp_mode);
  assign pair   = mode_pair(cmp_mode);

  xf_rx_match #(.DW(DW)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_mode  (cmp_mode),
    .rx_strobe (rx_strobe),
    .rx_byte   (rx_byte),
    .xon_a     (xon_a),
    .xon_b     (xon_b),
    .xoff_a    (xoff_a),
    .xoff_b    (xoff_b),
    .hit_off   (hit_off),
    .hit_on    (hit_on),
    .fwd_valid (fwd_valid),
    .fwd_byte  (fwd_byte)
  );

  xf_suspend u_susp (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .hit_off   (hit_off),
    .hit_on    (hit_on),
    .irq_en    (irq_en),
    .xoff_flag (xoff_flag),
    .irq       (irq)
  );

  xf_insert #(
    .DW       (DW),
    .CNT_W    (CNT_W),
    .NUM_TRIG (NUM_TRIG),
    .OFF_LVL  (OFF_LVL),
    .ON_LVL   (ON_LVL)
  ) u_ins (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .pair      (pair),
    .rx_fill   (rx_fill),
    .trig_sel  (trig_sel),
    .char_done (char_done),
    .xon_a     (xon_a),
    .xon_b     (xon_b),
    .xoff_a    (xoff_a),
    .xoff_b    (xoff_b),
    .fc_req    (fc_req),
    .fc_is_xon (fc_is_xon),
    .fc_byte   (fc_byte)
  );

  assign tx_allow = !xoff_flag && !fc_req;

endmodule

// File: rtl/xf_flow_checker.sv
module xf_flow_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    cmp_mode,
  input logic          rx_strobe,
  input logic [DW-1:0] rx_byte,
  input logic [DW-1:0] xoff_a,
  input logic          char_done,
  input logic          tx_allow,
  input logic          fc_req,
  input logic          fc_is_xon,
  input logic          xoff_flag,
  input logic          fwd_valid
);

  a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_mode == 2'b00) |=> (!fc_req && !xoff_flag));

  a_r2_single_pause_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_strobe && cmp_mode == 2'b01 && rx_byte == xoff_a) |=> (xoff_flag && !tx_allow));

  a_r5_flag_rise_needs_char: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xoff_flag) |-> $past(rx_strobe));

  a_r5_flag_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xoff_flag) |-> ($past(rx_strobe) || $past(cmp_mode == 2'b00)));

  a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_req && !char_done && cmp_mode != 2'b00) |=> (fc_req && $stable(fc_is_xon)));

  a_r8_insert_first: assert property (@(posedge clk) disable iff (!rst_n)
    fc_req |-> !tx_allow);

  a_r9_fwd_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> $past(rx_strobe));

endmodule

bind xonxoff_flow_ctrl xf_flow_checker #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmp_mode  (cmp_mode),
  .rx_strobe (rx_strobe),
  .rx_byte   (rx_byte),
  .xoff_a    (xoff_a),
  .char_done (char_done),
  .tx_allow  (tx_allow),
  .fc_req    (fc_req),
  .fc_is_xon (fc_is_xon),
  .xoff_flag (xoff_flag),
  .fwd_valid (fwd_valid)
);

// File: tb/xonxoff_flow_ctrl_bench.sv
`timescale 1ns/1ps
module xonxoff_flow_ctrl_bench;

  localparam logic [7:0] ON_A  = 8'h11;
  localparam logic [7:0] ON_B  = 8'h91;
  localparam logic [7:0] OFF_A = 8'h13;
  localparam logic [7:0] OFF_B = 8'h93;

  logic       clk;
  logic       rst_n;
  logic [1:0] cmp_mode;
  logic       rx_strobe;
  logic [7:0] rx_byte;
  logic [5:0] rx_fill;
  logic [1:0] trig_sel;
  logic       char_done;
  logic       irq_en;
  logic       tx_allow, fc_req, fc_is_xon, xoff_flag, irq, fwd_valid;
  logic [7:0] fc_byte, fwd_byte;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  xonxoff_flow_ctrl u_xonxoff_flow_ctrl (
    .clk(clk), .rst_n(rst_n), .cmp_mode(cmp_mode),
    .rx_strobe(rx_strobe), .rx_byte(rx_byte),
    .xon_a(ON_A), .xon_b(ON_B), .xoff_a(OFF_A), .xoff_b(OFF_B),
    .rx_fill(rx_fill), .trig_sel(trig_sel), .char_done(char_done),
    .irq_en(irq_en), .tx_allow(tx_allow), .fc_req(fc_req),
    .fc_is_xon(fc_is_xon), .fc_byte(fc_byte), .xoff_flag(xoff_flag),
    .irq(irq), .fwd_valid(fwd_valid), .fwd_byte(fwd_byte)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [7:0] b);
    rx_strobe = 1'b1;
    rx_byte   = b;
    tick();
    rx_strobe = 1'b0;
  endtask

  task automatic boundary();
    char_done = 1'b1;
    tick();
    char_done = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit model_flag;
    rst_n = 1'b0; cmp_mode = 2'b01; rx_strobe = 1'b0; rx_byte = 8'h00;
    rx_fill = '0; trig_sel = 2'd0; char_done = 1'b0; irq_en = 1'b1;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R10 reset state
    chk("R10 tx_allow", tx_allow, 1);
    chk("R10 fc_req", fc_req, 0);
    chk("R10 xoff_flag", xoff_flag, 0);
    chk("R10 irq", irq, 0);
    chk("R10 fwd_valid", fwd_valid, 0);

    // R2 R5 R9: single mode, every byte value
    model_flag = 0;
    for (int b = 0; b < 256; b++) begin
      send(8'(b));
      if (b == OFF_A) model_flag = 1;
      else if (b == ON_A) model_flag = 0;
      chk("R2 flag", xoff_flag, model_flag);
      chk("R2 tx_allow", tx_allow, !model_flag);
      chk("R5 irq", irq, model_flag);
      chk("R9 fwd_valid", fwd_valid, (b != OFF_A && b != ON_A));
      if (b != OFF_A && b != ON_A) chk("R9 fwd_byte", fwd_byte, b);
      tick();
      chk("R9 one-cycle pulse", fwd_valid, 0);
    end

    // R5 interrupt gating
    send(OFF_A);
    irq_en = 1'b0;
    #1;
    chk("R5 irq masked", irq, 0);
    chk("R5 flag kept", xoff_flag, 1);
    irq_en = 1'b1;

    // R1 mode off clears and passes everything
    cmp_mode = 2'b00;
    tick();
    chk("R1 flag cleared", xoff_flag, 0);
    chk("R1 tx_allow", tx_allow, 1);
    send(OFF_A);
    chk("R1 no match", xoff_flag, 0);
    chk("R1 forwarded", fwd_valid, 1);
    chk("R1 fwd byte", fwd_byte, OFF_A);
    rx_fill = 6'd32;
    tick(); tick();
    chk("R1 no request", fc_req, 0);
    rx_fill = '0;

    // R3 R4 two-character mode
    cmp_mode = 2'b10;
    tick();
    send(OFF_A); chk("R9 first of pair forwarded", fwd_valid, 1);
    chk("R3 no match yet", xoff_flag, 0);
    send(8'h41); chk("R4 breaker", xoff_flag, 0);
    send(OFF_B); chk("R4 broken pair no match", xoff_flag, 0);
    chk("R4 broken second forwarded", fwd_valid, 1);
    send(OFF_A); send(OFF_A);
    chk("R4 repeated first forwarded", fwd_valid, 1);
    send(OFF_B);
    chk("R4 re-judged pair matches", xoff_flag, 1);
    chk("R9 second dropped", fwd_valid, 0);
    chk("R3 tx_allow", tx_allow, 0);
    send(ON_A); chk("R3 still paused", xoff_flag, 1);
    send(ON_B); chk("R3 resume pair", xoff_flag, 0);
    chk("R9 resume second dropped", fwd_valid, 0);
    send(ON_A); send(ON_B);
    chk("R3 resume when running", xoff_flag, 0);
    chk("R3 resume byte dropped", fwd_valid, 0);
    send(ON_B); chk("R3 lone second forwarded", fwd_valid, 1);

    // R6 R7 R8 thresholds, single mode
    cmp_mode = 2'b01;
    for (int t = 0; t < 4; t++) begin
      int hi;
      int lo;
      hi = (t == 3) ? 28 : 8 * (t + 1);
      lo = (t == 0) ? 0 : 8 * t - 1;
      trig_sel = 2'(t);
      rx_fill  = '0;
      tick();
      chk("R7 no resume without pause", fc_req, 0);
      for (int f = 1; f <= 32; f++) begin
        rx_fill = 6'(f);
        tick();
        chk("R6 pause threshold", fc_req, (f >= hi));
        if (f >= hi) begin
          chk("R8 pause byte", fc_byte, OFF_A);
          chk("R8 pause kind", fc_is_xon, 0);
          chk("R8 data held back", tx_allow, 0);
        end
      end
      boundary();
      chk("R8 accepted", fc_req, 0);
      tick();
      chk("R7 once per crossing", fc_req, 0);
      for (int f = 31; f >= 0; f--) begin
        rx_fill = 6'(f);
        tick();
        chk("R6 resume threshold", fc_req, (f <= lo));
        if (f <= lo) begin
          chk("R8 resume byte", fc_byte, ON_A);
          chk("R8 resume kind", fc_is_xon, 1);
        end
      end
      boundary();
      chk("R8 resume accepted", fc_req, 0);
      tick();
      chk("R7 single resume", fc_req, 0);
    end

    // R8 two-character insertion
    cmp_mode = 2'b10; trig_sel = 2'd0; rx_fill = 6'd8;
    tick();
    chk("R8 pair pause req", fc_req, 1);
    chk("R8 pair pause first", fc_byte, OFF_A);
    boundary();
    chk("R8 pair pause still req", fc_req, 1);
    chk("R8 pair pause second", fc_byte, OFF_B);
    boundary();
    chk("R8 pair pause done", fc_req, 0);
    rx_fill = '0;
    tick();
    chk("R8 pair resume first", fc_byte, ON_A);
    chk("R8 pair resume req", fc_req, 1);
    boundary();
    chk("R8 pair resume second", fc_byte, ON_B);
    boundary();
    chk("R8 pair resume done", fc_req, 0);
    chk("R8 data released", tx_allow, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule